// File: doc/BRIEF.md
# Thermal Trip Shutdown Latch

This block guards a chip against runaway junction temperature. It watches two inputs. The first is the raw output of an over-temperature comparator, which is asynchronous. The second is a power-good level that is already synchronous to the block clock. From these it produces a sticky trip indication, an enable for the pin driver that carries that indication off chip, and a request to stop the internal clocks.

After power-good rises, the block first waits an arming window of `ARM_CYCLES` clock cycles with the trip driver disabled. The default window is the number of cycles in 10 µs at `CLK_MHZ`. Once armed, the first synchronized over-temperature sample latches the trip and raises the clock-halt request. Nothing clears the latch except power-good going low, and power-good low returns the block to its off state from any state. If the comparator still reads hot when power comes back, the trip fires again as soon as the new arming window ends.

The block has no streaming data path. All pins are plain levels with no valid/ready handshake and no back-pressure.

Top module: `thermal_trip_latch`

## Requirements
- R1: While `rst_n` is low and on the first cycles after reset with `pwr_ok` low, `drive_en`, `trip` and `halt_req` are all 0.
- R2: If `pwr_ok` is sampled low at a clock edge, then `drive_en`, `trip` and `halt_req` are all 0 after that edge, whatever the previous state.
- R3: Count the first edge that samples `pwr_ok` high after it was low as edge 1. `drive_en` becomes 1 after edge `ARM_CYCLES+1` and not earlier, provided `pwr_ok` stays high. `ARM_CYCLES` defaults to `CLK_MHZ*10`.
- R4: `trip` never rises before `drive_en` is 1, even if the comparator reads hot during the whole arming window.
- R5: `hot_raw` passes through a two-flop synchronizer. Setting it high before edge h gives a trip after edge max(h+2, `ARM_CYCLES`+2), where edge 1 is the power-good edge and a comparator already hot before power-up counts as h ≤ 0.
- R6: Once set, `trip` stays 1 while `pwr_ok` stays high, even after `hot_raw` returns low.
- R7: `halt_req` equals `trip` in every cycle. It has no release path of its own.
- R8: If `hot_raw` is still high across a power-good low pulse, `trip` asserts again after edge `ARM_CYCLES+2` of the new power-up.
- R9: A power-good drop during the arming window restarts the window. `drive_en` stays 0 until `ARM_CYCLES+1` edges after the next rise.
- R10: With `hot_raw` held low, `trip` stays 0 for the whole arming window and after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power-good level, synchronous to `clk` |
| hot_raw | input | 1 | Asynchronous over-temperature comparator output |
| drive_en | output | 1 | Trip pin driver enable (armed or tripped) |
| trip | output | 1 | Sticky thermal trip indication |
| halt_req | output | 1 | Request to stop internal clocks, follows `trip` |

## Verification
The bench moves the comparator's rising edge across every cycle from before power-up to well past the end of the arming window. A design with an off-by-one arming counter, or with a synchronizer of the wrong depth, would trip one cycle early or late. A design that ignored the arming state would trip during the window. The bench also drops the comparator right after a trip, which shows a latch that is not sticky. It cycles power-good while the comparator stays hot, which shows a design that never re-arms or that keeps the trip across the power cycle. It pulls power-good low at every cycle of the arming window, which shows a timer that resumes instead of restarting.

// File: rtl/ttl_pkg.sv
package ttl_pkg;

  typedef enum logic [1:0] {
    TT_OFF     = 2'd0,
    TT_ARMING  = 2'd1,
    TT_ARMED   = 2'd2,
    TT_TRIPPED = 2'd3
  } tt_state_e;

  function automatic logic tt_drives(input tt_state_e s);
    return (s == TT_ARMED) || (s == TT_TRIPPED);
  endfunction

endpackage

// File: rtl/ttl_sync.sv
module ttl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[0] <= 1'b0;
          else        sr[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[i] <= 1'b0;
          else        sr[i] <= sr[i-1];
        end
      end
    end
  endgenerate

  assign q = sr[STAGES-1];

endmodule

// File: rtl/ttl_arm_timer.sv
module ttl_arm_timer #(
  parameter int ARM_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = (ARM_CYCLES < 2) ? 1 : $clog2(ARM_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(ARM_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || done)   cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end

  assign done = run && (cnt == LAST);

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R3

  AST_CNT_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R9

endmodule

// File: rtl/ttl_fsm.sv
module ttl_fsm
  import ttl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_ok,
  input  logic      hot_q,
  input  logic      arm_done,
  output tt_state_e state
);

  tt_state_e nxt;

  always_comb begin
    nxt = state;
    if (!pwr_ok) begin
      nxt = TT_OFF;
    end else begin
      unique case (state)
        TT_OFF:     nxt = TT_ARMING;
        TT_ARMING:  nxt = arm_done ? TT_ARMED : TT_ARMING;
        TT_ARMED:   nxt = hot_q ? TT_TRIPPED : TT_ARMED;
        TT_TRIPPED: nxt = TT_TRIPPED;
        default:    nxt = TT_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= TT_OFF;
    else        state <= nxt;
  end

  AST_PWR_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (state == TT_OFF)); // R2

  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TT_TRIPPED) && pwr_ok |=> (state == TT_TRIPPED)); // R6

  AST_TRIP_ON_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == TT_TRIPPED) |-> $past(hot_q)); // R5

  AST_ARMED_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == TT_ARMED) |-> $past(arm_done)); // R3

endmodule

// File: rtl/thermal_trip_latch.sv
module thermal_trip_latch
  import ttl_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int ENABLE_US   = 10,
  parameter int ARM_CYCLES  = CLK_MHZ * ENABLE_US,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic hot_raw,
  output logic drive_en,
  output logic trip,
  output logic halt_req
);

  tt_state_e state;
  logic      hot_q;
  logic      arm_done;

  ttl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (hot_raw),
    .q     (hot_q)
  );

  ttl_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == TT_ARMING),
    .done  (arm_done)
  );

  ttl_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (pwr_ok),
    .hot_q    (hot_q),
    .arm_done (arm_done),
    .state    (state)
  );

  assign drive_en = tt_drives(state);
  assign trip     = (state == TT_TRIPPED);
  assign halt_req = trip;

  AST_TRIP_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip) |-> $past(drive_en)); // R4

  AST_EN_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> $past(pwr_ok)); // R3

  AST_OUTS_OFF_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !drive_en && !trip && !halt_req); // R2

endmodule

// File: tb/test_thermal_trip_latch.sv
module test_thermal_trip_latch;

  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic hot_raw = 1'b0;
  logic drive_en, trip, halt_req;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  thermal_trip_latch #(.ARM_CYCLES(N)) i_thermal_trip_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (pwr_ok),
    .hot_raw  (hot_raw),
    .drive_en (drive_en),
    .trip     (trip),
    .halt_req (halt_req)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic chk_all_low(input string req);
    chk(req, "drive_en", drive_en, 1'b0);
    chk(req, "trip", trip, 1'b0);
    chk(req, "halt_req", halt_req, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int tr;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk_all_low("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_all_low("R1");

    // Trip timing sweep: h = edge before which hot rises (0 = already hot)
    for (int h = 0; h <= N + 5; h++) begin
      pwr_ok = 1'b0;
      hot_raw = (h == 0);
      repeat (4) @(negedge clk);
      chk_all_low("R2");
      tr = (h + 2 > N + 2) ? h + 2 : N + 2;
      pwr_ok = 1'b1;
      if (h == 1) hot_raw = 1'b1;
      for (int e = 1; e <= N + 12; e++) begin
        @(negedge clk);
        chk("R3", "drive_en", drive_en, (e >= N + 1));
        if (e < N + 1) chk("R4", "trip early", trip, 1'b0);
        else if (e <= tr + 1) chk("R5", "trip timing", trip, (e >= tr));
        else chk("R6", "trip sticky", trip, 1'b1);
        chk("R7", "halt_req", halt_req, trip);
        if (e + 1 == h) hot_raw = 1'b1;
        if (e == tr + 1) hot_raw = 1'b0;
      end
      // power cycle with comparator hot: re-trip
      hot_raw = 1'b1;
      @(negedge clk);
      pwr_ok = 1'b0;
      @(negedge clk);
      chk_all_low("R2");
      pwr_ok = 1'b1;
      for (int e = 1; e <= N + 4; e++) begin
        @(negedge clk);
        chk("R8", "re-trip", trip, (e >= N + 2));
        chk("R8", "drive_en", drive_en, (e >= N + 1));
        chk("R7", "halt_req", halt_req, (e >= N + 2));
      end
      pwr_ok = 1'b0;
      hot_raw = 1'b0;
      @(negedge clk);
      chk_all_low("R2");
    end

    // Power drop at every point of the arming window, comparator cold
    for (int k = 1; k <= N + 1; k++) begin
      pwr_ok = 1'b0;
      hot_raw = 1'b0;
      repeat (3) @(negedge clk);
      pwr_ok = 1'b1;
      for (int e = 1; e <= k; e++) begin
        @(negedge clk);
        chk("R3", "drive_en", drive_en, (e >= N + 1));
        chk("R10", "trip cold", trip, 1'b0);
      end
      pwr_ok = 1'b0;
      @(negedge clk);
      chk_all_low("R2");
      pwr_ok = 1'b1;
      for (int e = 1; e <= N + 4; e++) begin
        @(negedge clk);
        chk("R9", "drive_en restart", drive_en, (e >= N + 1));
        chk("R10", "trip cold", trip, 1'b0);
        chk("R7", "halt_req", halt_req, 1'b0);
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule